// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block couples two parallel buses, A and B, through a pair of one-direction paths. Each path has its own storage register, loaded by its own capture strobe, plus an output enable and a source select. The select picks whether a bus is fed the live value of the opposite bus or the contents of the path register. A-side capture stores bus A into the A-to-B register. B-side capture stores bus B into the B-to-A register. Both captures happen whatever the selects and enables are set to.

Each bus is brought out as three separate groups: an external input, an output value and a drive flag. Whatever is attached to a bus resolves it as "driven value when the drive flag is set, else external value". The block resolves both buses in the same way internally, before any register loads. When both paths drive live data into each other and nothing else drives either bus, the two buses form a loop. In that case both buses keep the last value that bus A had. No path register is used for this.

The capture strobes are clock enables sampled on the rising edge of the single system clock. The reset is asynchronous and active low. It is expected to arrive already synchronised to the clock on its release.

Top module: `regd_bus_xcvr`

## Requirements
- R1: When `a_cap` is high at a rising clock edge, the A-to-B register loads the resolved bus A value of that cycle. This happens for every setting of the selects and enables.
- R2: When `b_cap` is high at a rising clock edge, the B-to-A register loads the resolved bus B value of that cycle. This happens for every setting of the selects and enables.
- R3: The enable `ab_oe` is active high. When it is 1, `b_drv` is 1 and bus B is driven. When it is 0, `b_drv` is 0 and `b_out` is all zeros.
- R4: The enable `ba_oe_n` is active low. When it is 0, `a_drv` is 1 and bus A is driven. When it is 1, `a_drv` is 0 and `a_out` is all zeros.
- R5: While bus B is driven, `ab_sel` = 0 puts the resolved bus A value on `b_out`, and `ab_sel` = 1 puts the A-to-B register on `b_out`.
- R6: While bus A is driven, `ba_sel` = 0 puts the resolved bus B value on `a_out`, and `ba_sel` = 1 puts the B-to-A register on `a_out`.
- R7: With `ab_oe` = 0 and `ba_oe_n` = 1, neither bus is driven and both captures still load their external bus values.
- R8: With both buses driven and both selects at 1, `b_out` shows the A-to-B register and `a_out` shows the B-to-A register in the same cycle.
- R9: With both buses driven and both selects at 0, both outputs show the resolved bus A value from the previous cycle. This value holds for as long as the loop lasts.
- R10: With bus B driven live from bus A and bus A not driven, `a_cap` and `b_cap` high in the same cycle load `a_in` into both registers.
- R11: Reset clears both registers and the held loop value to zero.
- R12: A capture that takes a bus the block itself drives stores the driven value and not the external input. For example, with bus A driven from the B-to-A register, `a_cap` copies that register into the A-to-B register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_cap | input | 1 | Capture strobe for bus A into the A-to-B register |
| b_cap | input | 1 | Capture strobe for bus B into the B-to-A register |
| ab_oe | input | 1 | Drive enable for bus B, active high |
| ba_oe_n | input | 1 | Drive enable for bus A, active low |
| ab_sel | input | 1 | Source for bus B: 0 live A, 1 stored |
| ba_sel | input | 1 | Source for bus A: 0 live B, 1 stored |
| a_in | input | WIDTH | External value present on bus A |
| b_in | input | WIDTH | External value present on bus B |
| a_out | output | WIDTH | Value driven onto bus A, zero when not driven |
| a_drv | output | 1 | Bus A is driven by the block |
| b_out | output | WIDTH | Value driven onto bus B, zero when not driven |
| b_drv | output | 1 | Bus B is driven by the block |

## Verification
The assertions assume that `a_in` and `b_in` describe the bus only where the block does not drive it. Several properties therefore qualify live pass-through on the far side being undriven, so that the external value is the resolved value. The register readback properties assume that the bus read back was undriven when it was captured. The stimulus keeps every control as a clean level that is set just after a clock edge and held for the whole cycle. It walks each enable and select combination, including the loop and the same-cycle double capture. A stretch of random controls and data then runs against the bench's reference model.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_t;
endpackage

// File: rtl/xcvr_store_reg.sv
module xcvr_store_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (load) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/xcvr_bus_resolve.sv
module xcvr_bus_resolve
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             a_en,
  input  logic             b_en,
  input  src_t             to_b_src,
  input  src_t             to_a_src,
  input  logic [WIDTH-1:0] a_ext,
  input  logic [WIDTH-1:0] b_ext,
  input  logic [WIDTH-1:0] ab_q,
  input  logic [WIDTH-1:0] ba_q,
  input  logic [WIDTH-1:0] loop_q,
  output logic [WIDTH-1:0] a_bus,
  output logic [WIDTH-1:0] b_bus
);
  // Loop: each bus fed live from the other, nothing else driving.
  logic loop_on;
  assign loop_on = a_en && b_en && (to_b_src == SRC_LIVE) && (to_a_src == SRC_LIVE);

  always_comb begin
    if (loop_on) begin
      a_bus = loop_q;
      b_bus = loop_q;
    end else begin
      if (!a_en)                      a_bus = a_ext;
      else if (to_a_src == SRC_STORED) a_bus = ba_q;
      else if (!b_en)                  a_bus = b_ext;
      else                             a_bus = ab_q;

      if (!b_en)                      b_bus = b_ext;
      else if (to_b_src == SRC_STORED) b_bus = ab_q;
      else if (!a_en)                  b_bus = a_ext;
      else                             b_bus = ba_q;
    end
  end
endmodule

// File: rtl/regd_bus_xcvr.sv
module regd_bus_xcvr
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_cap,
  input  logic             b_cap,
  input  logic             ab_oe,
  input  logic             ba_oe_n,
  input  logic             ab_sel,
  input  logic             ba_sel,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_drv,
  output logic [WIDTH-1:0] b_out,
  output logic             b_drv
);
  localparam int NREG = 3;
  localparam int IDX_AB = 0;
  localparam int IDX_BA = 1;
  localparam int IDX_LOOP = 2;

  logic             a_en, b_en;
  logic [WIDTH-1:0] a_bus, b_bus;
  logic [WIDTH-1:0] reg_d [NREG];
  logic [WIDTH-1:0] reg_q [NREG];
  logic [NREG-1:0]  reg_ld;

  assign a_en = ~ba_oe_n;
  assign b_en = ab_oe;

  xcvr_bus_resolve #(.WIDTH(WIDTH)) u_resolve (
    .a_en     (a_en),
    .b_en     (b_en),
    .to_b_src (src_t'(ab_sel)),
    .to_a_src (src_t'(ba_sel)),
    .a_ext    (a_in),
    .b_ext    (b_in),
    .ab_q     (reg_q[IDX_AB]),
    .ba_q     (reg_q[IDX_BA]),
    .loop_q   (reg_q[IDX_LOOP]),
    .a_bus    (a_bus),
    .b_bus    (b_bus)
  );

  always_comb begin
    reg_d[IDX_AB]   = a_bus;
    reg_d[IDX_BA]   = b_bus;
    reg_d[IDX_LOOP] = a_bus;
    reg_ld          = '0;
    reg_ld[IDX_AB]   = a_cap;
    reg_ld[IDX_BA]   = b_cap;
    reg_ld[IDX_LOOP] = 1'b1;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_store
    xcvr_store_reg #(.WIDTH(WIDTH)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (reg_ld[g]),
      .d     (reg_d[g]),
      .q     (reg_q[g])
    );
  end

  assign a_drv = a_en;
  assign b_drv = b_en;
  assign a_out = a_en ? a_bus : '0;
  assign b_out = b_en ? b_bus : '0;
endmodule

// File: rtl/regd_bus_xcvr_chk.sv
module regd_bus_xcvr_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             a_cap,
  input logic             b_cap,
  input logic             ab_oe,
  input logic             ba_oe_n,
  input logic             ab_sel,
  input logic             ba_sel,
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] b_in,
  input logic [WIDTH-1:0] a_out,
  input logic             a_drv,
  input logic [WIDTH-1:0] b_out,
  input logic             b_drv
);
  logic loop_now;
  assign loop_now = ab_oe && !ba_oe_n && !ab_sel && !ba_sel;

  a_r3_b_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ab_oe |-> (!b_drv && b_out == '0));

  a_r4_a_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ba_oe_n |-> (!a_drv && a_out == '0));

  a_r5_live_to_b: assert property (@(posedge clk) disable iff (!rst_n)
    (ab_oe && !ab_sel && ba_oe_n) |-> (b_drv && b_out == a_in));

  a_r6_live_to_a: assert property (@(posedge clk) disable iff (!rst_n)
    (!ba_oe_n && !ba_sel && !ab_oe) |-> (a_drv && a_out == b_in));

  a_r1_store_a: assert property (@(posedge clk) disable iff (!rst_n)
    (a_cap && ba_oe_n) ##1 (ab_oe && ab_sel) |-> b_out == $past(a_in));

  a_r2_store_b: assert property (@(posedge clk) disable iff (!rst_n)
    (b_cap && !ab_oe) ##1 (!ba_oe_n && ba_sel) |-> a_out == $past(b_in));

  a_r9_loop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_now && $past(loop_now)) |-> (a_out == $past(a_out) && b_out == a_out));
endmodule

bind regd_bus_xcvr regd_bus_xcvr_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/test_regd_bus_xcvr.sv
module test_regd_bus_xcvr;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       a_cap, b_cap, ab_oe, ba_oe_n, ab_sel, ba_sel;
  logic [7:0] a_in, b_in;
  logic [7:0] a_out, b_out;
  logic       a_drv, b_drv;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  string cur_req = "R11";

  // Reference state
  int m_ab, m_ba, m_hold;

  always #4 clk = ~clk;

  regd_bus_xcvr i_regd_bus_xcvr (
    .clk(clk), .rst_n(rst_n), .a_cap(a_cap), .b_cap(b_cap),
    .ab_oe(ab_oe), .ba_oe_n(ba_oe_n), .ab_sel(ab_sel), .ba_sel(ba_sel),
    .a_in(a_in), .b_in(b_in), .a_out(a_out), .a_drv(a_drv),
    .b_out(b_out), .b_drv(b_drv)
  );

  // Settle both bus values from the model state and present inputs.
  function automatic void settle(output int ra, output int rb);
    bit da = !ba_oe_n;
    bit db = ab_oe;
    bit ka, kb;
    ka = 0; kb = 0; ra = 0; rb = 0;
    if (!da)        begin ra = a_in;  ka = 1; end
    else if (ba_sel) begin ra = m_ba; ka = 1; end
    if (!db)        begin rb = b_in;  kb = 1; end
    else if (ab_sel) begin rb = m_ab; kb = 1; end
    if (!ka && !kb) begin ra = m_hold; rb = m_hold; end
    else if (!ka)   ra = rb;
    else if (!kb)   rb = ra;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    int ra, rb;
    if (!rst_n) begin
      m_ab = 0; m_ba = 0; m_hold = 0;
    end else begin
      settle(ra, rb);
      if (a_cap) m_ab = ra;
      if (b_cap) m_ba = rb;
      m_hold = ra;
    end
  end

  task automatic check(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    int ra, rb;
    settle(ra, rb);
    check("a_drv", a_drv, !ba_oe_n);
    check("b_drv", b_drv, ab_oe);
    check("a_out", a_out, ba_oe_n ? 0 : ra);
    check("b_out", b_out, ab_oe ? rb : 0);
  endtask

  // ctl bits: {a_cap, b_cap, ab_oe, ba_oe_n, ab_sel, ba_sel}
  task automatic cyc(string req, logic [5:0] ctl, logic [7:0] av, logic [7:0] bv);
    @(posedge clk);
    #1;
    cur_req = req;
    {a_cap, b_cap, ab_oe, ba_oe_n, ab_sel, ba_sel} = ctl;
    a_in = av; b_in = bv;
    #2;
    compare_all();
  endtask

  initial begin
    rst_n = 0;
    {a_cap, b_cap, ab_oe, ba_oe_n, ab_sel, ba_sel} = 6'b001011;
    a_in = 8'h11; b_in = 8'h22;
    #3;
    // R11: stored paths read back zero during reset
    check("a_out in reset", a_out, 0);
    check("b_out in reset", b_out, 0);
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    cyc("R11", 6'b001011, 8'h77, 8'h66);
    check("R11 stored B path zero", a_out, 0);
    check("R11 stored A path zero", b_out, 0);
    // R7: isolation, both captures
    cyc("R7", 6'b110100, 8'h3C, 8'hA5);
    check("R7 isolated a_drv", a_drv, 0);
    check("R7 isolated b_drv", b_drv, 0);
    // R8, R1, R2: read both back at once
    cyc("R8", 6'b001011, 8'h00, 8'h00);
    check("R1 stored A on B", b_out, 8'h3C);
    check("R2 stored B on A", a_out, 8'hA5);
    // R5, R3: live A to B
    cyc("R5", 6'b001100, 8'h81, 8'h00);
    check("R5 live 81", b_out, 8'h81);
    cyc("R5", 6'b001100, 8'hFE, 8'h13);
    check("R5 live FE", b_out, 8'hFE);
    cyc("R3", 6'b000100, 8'h55, 8'h13);
    check("R3 b_out zero", b_out, 0);
    // R6, R4: live B to A
    cyc("R6", 6'b000000, 8'h00, 8'h4D);
    check("R6 live 4D", a_out, 8'h4D);
    cyc("R4", 6'b000100, 8'h09, 8'h4D);
    check("R4 a_out zero", a_out, 0);
    // R10: B live from A, both captures together
    cyc("R10", 6'b111100, 8'hC3, 8'h99);
    cyc("R10", 6'b001011, 8'h00, 8'h00);
    check("R10 A-to-B reg", b_out, 8'hC3);
    check("R10 B-to-A reg", a_out, 8'hC3);
    // R12: A driven from stored B, capture A ignores a_in
    cyc("R2", 6'b010100, 8'h00, 8'h6E);
    cyc("R12", 6'b100001, 8'hF0, 8'h00);
    cyc("R12", 6'b001111, 8'h00, 8'h00);
    check("R12 self-driven capture", b_out, 8'h6E);
    // R9: loop holds previous bus A
    cyc("R9", 6'b000100, 8'h5A, 8'h01);
    cyc("R9", 6'b001000, 8'h12, 8'h34);
    check("R9 loop a", a_out, 8'h5A);
    check("R9 loop b", b_out, 8'h5A);
    cyc("R9", 6'b111000, 8'hEE, 8'hDD);
    check("R9 loop held", a_out, 8'h5A);
    cyc("R9", 6'b001011, 8'h00, 8'h00);
    check("R9 loop captured into A-to-B", b_out, 8'h5A);
    check("R9 loop captured into B-to-A", a_out, 8'h5A);
    // R1/R2 mixed: random controls against the model
    for (int i = 0; i < 400; i++)
      cyc((i % 2) ? "R1" : "R2", 6'($urandom), 8'($urandom), 8'($urandom));
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end
endmodule